// File: doc/BRIEF.md
# Accumulator Readout Rounding Formatter

This block turns a 64-bit multiply-accumulate result into a 32-bit register value. A request strobe presents the accumulator together with a readout mode and three control bits. One clock later the formatted word appears with a valid pulse. The readout mode is one of signed integer, unsigned integer or fractional.

Integer readout always clamps to the 32-bit range of the selected signedness. Fractional readout has two shapes. The half-width shape takes a 16-bit field from above a 24-bit remainder and always rounds it half-to-even. The full-width shape shifts the accumulator arithmetically right by 8 and can optionally round the dropped byte half-to-even. An overflow-mode control bit picks saturation or wrap-around when the fractional result does not fit.

The block holds no accumulator state and updates no flags. It is a formatting stage that sits between the accumulator file and the register write port.

Top module: `acc_readout_fmt`

## Requirements
- R1: While reset is asserted and after its release, before any request, `vld_o` is 0 and `res_o` is 0.
- R2: A request in one cycle produces `vld_o` = 1 in the next cycle only. `res_o` changes only in the cycle after a request and holds its value otherwise.
- R3: With `mode_i` = 2'b00 (signed integer), the result is `acc_i[31:0]` when `acc_i` fits in signed 32 bits. Otherwise it is 0x7FFFFFFF for a non-negative accumulator and 0x80000000 for a negative one, whatever `sat_i`, `round_i` and `half_i` are.
- R4: With `mode_i` = 2'b01 (unsigned integer), the result is `acc_i[31:0]` when `acc_i[63:32]` is zero, and 0xFFFFFFFF otherwise.
- R5: With `mode_i[1]` = 1 (fractional) and `half_i` = 1, the value is `acc_i[39:24]` and the remainder is `acc_i[23:0]`. The value goes up by one when the remainder exceeds 0x800000, and on a remainder of exactly 0x800000 only when the value is odd. Result bits 31:16 are zero.
- R6: In half-width fractional readout, if rounding carries out of 16 bits, the result is 0x7FFF when `sat_i` = 1 and 0x0000 when `sat_i` = 0.
- R7: In fractional readout with `half_i` = 0 and `round_i` = 1, the value is `acc_i` shifted arithmetically right by 8. It goes up by one when `acc_i[7:0]` exceeds 0x80, and on exactly 0x80 only when the value is odd.
- R8: In fractional readout with `half_i` = 0 and `round_i` = 0, the value is `acc_i` shifted arithmetically right by 8 with no rounding.
- R9: In full-width fractional readout, a value outside the signed 32-bit range gives 0x7FFFFFFF (accumulator bit 63 clear) or 0x80000000 (bit 63 set) when `sat_i` = 1, and the low 32 bits of the value when `sat_i` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Readout request strobe |
| mode_i | input | 2 | 00 signed integer, 01 unsigned integer, 1x fractional |
| half_i | input | 1 | Fractional: 1 selects 16-bit result |
| round_i | input | 1 | Full-width fractional: enable half-even rounding |
| sat_i | input | 1 | Fractional: saturate on overflow |
| acc_i | input | 64 | Accumulator value |
| res_o | output | 32 | Formatted result |
| vld_o | output | 1 | Result valid pulse |

## Verification
The properties assume that `req_i`, `mode_i`, the control bits and `acc_i` are known and stable around each rising edge. They also assume that `req_i` stays low while reset is held, because every check compares the output one cycle after a request with the inputs that went with it. The stimulus changes all inputs only on the falling clock edge and keeps the request low through reset. It raises the request for single cycles, and between requests it deliberately alters `acc_i` and the mode so that the hold behaviour is exercised.

// File: rtl/acc_fmt_pkg.sv
package acc_fmt_pkg;
  typedef enum logic [1:0] {
    RD_SIGNED   = 2'b00,
    RD_UNSIGNED = 2'b01,
    RD_FRAC     = 2'b10,
    RD_FRAC_ALT = 2'b11
  } rd_mode_e;
endpackage

// File: rtl/acc_fmt_int.sv
// Integer readout: clamp to signed or unsigned result range.
module acc_fmt_int #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             uns_i,
  output logic [RES_W-1:0] res_o
);
  localparam logic [RES_W-1:0] SMAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] SMIN = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] UMAX = {RES_W{1'b1}};

  logic s_fits, u_fits;
  logic [RES_W-1:0] s_res, u_res;

  always_comb begin
    s_fits = (&acc_i[ACC_W-1:RES_W-1]) | ~(|acc_i[ACC_W-1:RES_W-1]);
    u_fits = ~(|acc_i[ACC_W-1:RES_W]);
    s_res  = s_fits ? acc_i[RES_W-1:0] : (acc_i[ACC_W-1] ? SMIN : SMAX);
    u_res  = u_fits ? acc_i[RES_W-1:0] : UMAX;
    res_o  = uns_i ? u_res : s_res;
  end
endmodule

// File: rtl/acc_fmt_frac.sv
// Fractional readout: half-width (always rounded) or full-width (optional rounding).
module acc_fmt_frac #(
  parameter int ACC_W      = 64,
  parameter int RES_W      = 32,
  parameter int HALF_W     = 16,
  parameter int HALF_SHIFT = 24,
  parameter int FULL_SHIFT = 8
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             half_i,
  input  logic             round_i,
  input  logic             sat_i,
  output logic [RES_W-1:0] res_o
);
  localparam int SH_W = ACC_W - FULL_SHIFT;  // width of shifted full value
  localparam logic [HALF_SHIFT-1:0] H_TIE = {1'b1, {(HALF_SHIFT-1){1'b0}}};
  localparam logic [FULL_SHIFT-1:0] F_TIE = {1'b1, {(FULL_SHIFT-1){1'b0}}};
  localparam logic [HALF_W-1:0] H_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [RES_W-1:0]  SMAX  = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0]  SMIN  = {1'b1, {(RES_W-1){1'b0}}};

  // half-width path
  logic [HALF_W-1:0]     h_val;
  logic [HALF_SHIFT-1:0] h_rem;
  logic                  h_up;
  logic [HALF_W:0]       h_sum;
  logic [HALF_W-1:0]     h_res;

  always_comb begin
    h_val = acc_i[HALF_SHIFT +: HALF_W];
    h_rem = acc_i[HALF_SHIFT-1:0];
    h_up  = (h_rem > H_TIE) | ((h_rem == H_TIE) & h_val[0]);
    h_sum = {1'b0, h_val} + {{HALF_W{1'b0}}, h_up};
    if (h_sum[HALF_W]) h_res = sat_i ? H_MAX : '0;
    else               h_res = h_sum[HALF_W-1:0];
  end

  // full-width path
  logic [SH_W-1:0]       f_val;
  logic [FULL_SHIFT-1:0] f_rem;
  logic                  f_up;
  logic [SH_W:0]         f_sum;
  logic                  f_fits;
  logic [RES_W-1:0]      f_res;

  always_comb begin
    f_val  = acc_i[ACC_W-1:FULL_SHIFT];
    f_rem  = acc_i[FULL_SHIFT-1:0];
    f_up   = round_i & ((f_rem > F_TIE) | ((f_rem == F_TIE) & f_val[0]));
    f_sum  = {f_val[SH_W-1], f_val} + {{SH_W{1'b0}}, f_up};
    f_fits = (&f_sum[SH_W:RES_W-1]) | ~(|f_sum[SH_W:RES_W-1]);
    if (!f_fits && sat_i) f_res = acc_i[ACC_W-1] ? SMIN : SMAX;
    else                  f_res = f_sum[RES_W-1:0];
  end

  assign res_o = half_i ? {{(RES_W-HALF_W){1'b0}}, h_res} : f_res;
endmodule

// File: rtl/acc_readout_fmt.sv
module acc_readout_fmt
  import acc_fmt_pkg::*;
#(
  parameter int ACC_W      = 64,
  parameter int RES_W      = 32,
  parameter int HALF_W     = 16,
  parameter int HALF_SHIFT = 24,
  parameter int FULL_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [1:0]       mode_i,
  input  logic             half_i,
  input  logic             round_i,
  input  logic             sat_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [RES_W-1:0] res_o,
  output logic             vld_o
);
  rd_mode_e         mode;
  logic [RES_W-1:0] int_res, frac_res;
  logic [RES_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;

  assign mode = rd_mode_e'(mode_i);

  acc_fmt_int #(.ACC_W(ACC_W), .RES_W(RES_W)) u_int (
    .acc_i (acc_i),
    .uns_i (mode == RD_UNSIGNED),
    .res_o (int_res)
  );

  acc_fmt_frac #(
    .ACC_W(ACC_W), .RES_W(RES_W), .HALF_W(HALF_W),
    .HALF_SHIFT(HALF_SHIFT), .FULL_SHIFT(FULL_SHIFT)
  ) u_frac (
    .acc_i   (acc_i),
    .half_i  (half_i),
    .round_i (round_i),
    .sat_i   (sat_i),
    .res_o   (frac_res)
  );

  // next state
  always_comb begin
    vld_d = req_i;
    res_d = res_q;
    if (req_i) begin
      unique case (mode)
        RD_FRAC, RD_FRAC_ALT: res_d = frac_res;
        default:              res_d = int_res;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (req_i) res_q <= res_d;
    end
  end

  assign res_o = res_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/acc_readout_fmt_chk.sv
module acc_readout_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic [1:0]  mode_i,
  input logic        half_i,
  input logic        sat_i,
  input logic [63:0] acc_i,
  input logic [31:0] res_o,
  input logic        vld_o
);
  logic s_in_range;
  assign s_in_range = (&acc_i[63:31]) | ~(|acc_i[63:31]);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !vld_o); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(res_o)); // R2
  AST_SIGNED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 2'b00 && s_in_range) |=> res_o == $past(acc_i[31:0])); // R3
  AST_UNSIGNED_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 2'b01 && (|acc_i[63:32])) |=> res_o == 32'hFFFF_FFFF); // R4
  AST_HALF_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i[1] && half_i) |=> res_o[31:16] == 16'h0000); // R5
  AST_HALF_CARRY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i[1] && half_i && sat_i && acc_i[39:24] == 16'hFFFF
     && acc_i[23:0] > 24'h80_0000) |=> res_o == 32'h0000_7FFF); // R6
endmodule

bind acc_readout_fmt acc_readout_fmt_chk chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .mode_i (mode_i),
  .half_i (half_i),
  .sat_i  (sat_i),
  .acc_i  (acc_i),
  .res_o  (res_o),
  .vld_o  (vld_o)
);

// File: tb/acc_readout_fmt_test.sv
`timescale 1ns/1ps
module acc_readout_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [1:0]  mode;
  logic        half, rnd, sat;
  logic [63:0] acc;
  logic [31:0] res;
  logic        vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  acc_readout_fmt uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode),
    .half_i(half), .round_i(rnd), .sat_i(sat), .acc_i(acc),
    .res_o(res), .vld_o(vld)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one request; checks valid pulse and result one cycle later
  task automatic readout(input string tag, input logic [1:0] m, input logic h,
                         input logic r, input logic s, input logic [63:0] a,
                         input logic [31:0] exp);
    @(negedge clk);
    req = 1'b1; mode = m; half = h; rnd = r; sat = s; acc = a;
    @(negedge clk);
    req = 1'b0;
    check({tag, " valid"}, {31'b0, vld}, 32'd1);
    check(tag, res, exp);
  endtask

  task automatic t_reset;
    check("R1 vld", {31'b0, vld}, 32'd0);
    check("R1 res", res, 32'd0);
  endtask

  task automatic t_signed;
    readout("R3 fit pos", 2'b00, 0, 0, 0, 64'h0000_0000_7FFF_FFFF, 32'h7FFF_FFFF);
    readout("R3 fit neg", 2'b00, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 32'hFFFF_FFFE);
    readout("R3 over pos", 2'b00, 0, 0, 0, 64'h0000_0000_8000_0000, 32'h7FFF_FFFF);
    readout("R3 fit min", 2'b00, 0, 0, 0, 64'hFFFF_FFFF_8000_0000, 32'h8000_0000);
    readout("R3 over neg", 2'b00, 1, 1, 0, 64'hFFFF_FFFF_7FFF_FFFF, 32'h8000_0000);
  endtask

  task automatic t_unsigned;
    readout("R4 fit", 2'b01, 0, 0, 0, 64'h0000_0000_DEAD_BEEF, 32'hDEAD_BEEF);
    readout("R4 over", 2'b01, 0, 0, 0, 64'h0000_0001_0000_0000, 32'hFFFF_FFFF);
    readout("R4 top", 2'b01, 0, 0, 1, 64'h8000_0000_0000_0001, 32'hFFFF_FFFF);
  endtask

  task automatic t_half;
    readout("R5 tie even", 2'b10, 1, 0, 0, 64'h0000_0012_3480_0000, 32'h0000_1234);
    readout("R5 tie odd", 2'b10, 1, 0, 0, 64'h0000_0012_3580_0000, 32'h0000_1236);
    readout("R5 above", 2'b10, 1, 0, 0, 64'h0000_0012_3480_0001, 32'h0000_1235);
    readout("R5 below", 2'b11, 1, 1, 0, 64'hFF00_0012_347F_FFFF, 32'h0000_1234);
    readout("R6 carry sat", 2'b10, 1, 0, 1, 64'h0000_00FF_FF90_0000, 32'h0000_7FFF);
    readout("R6 carry wrap", 2'b10, 1, 0, 0, 64'h0000_00FF_FF90_0000, 32'h0000_0000);
  endtask

  task automatic t_full;
    readout("R7 tie even", 2'b10, 0, 1, 0, 64'h0000_0000_1234_5680, 32'h0012_3456);
    readout("R7 tie odd", 2'b10, 0, 1, 0, 64'h0000_0000_1234_5780, 32'h0012_3458);
    readout("R7 above", 2'b11, 0, 1, 0, 64'h0000_0000_1234_5681, 32'h0012_3457);
    readout("R7 neg tie", 2'b10, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FF80, 32'h0000_0000);
    readout("R8 trunc", 2'b10, 0, 0, 0, 64'h0000_0000_1234_56FF, 32'h0012_3456);
    readout("R8 neg", 2'b10, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FE80, 32'hFFFF_FFFE);
    readout("R9 pos sat", 2'b10, 0, 0, 1, 64'h0000_0080_0000_0000, 32'h7FFF_FFFF);
    readout("R9 pos wrap", 2'b10, 0, 0, 0, 64'h0000_0080_0000_0000, 32'h8000_0000);
    readout("R9 neg sat", 2'b10, 0, 0, 1, 64'h8000_0000_0000_0000, 32'h8000_0000);
    readout("R9 neg wrap", 2'b10, 0, 0, 0, 64'h8000_0000_0000_0000, 32'h0000_0000);
    readout("R9 round over", 2'b10, 0, 1, 1, 64'h0000_007F_FFFF_FF80, 32'h7FFF_FFFF);
  endtask

  task automatic t_hold;
    readout("R2 setup", 2'b01, 0, 0, 0, 64'h0000_0000_CAFE_F00D, 32'hCAFE_F00D);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      acc = {32'h0, 32'h1111_1111 * i}; mode = 2'(i);
      check("R2 no valid", {31'b0, vld}, 32'd0);
      check("R2 hold", res, 32'hCAFE_F00D);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; mode = 2'b00; half = 0; rnd = 0; sat = 0;
    acc = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signed();
    t_unsigned();
    t_half();
    t_full();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule